// File: doc/BRIEF.md
# Raster Scan Timing and Vertical Blank Generator

This block walks the raster of a tile-based video controller. A horizontal dot counter and a vertical line counter advance by one position on each clock edge where the dot enable is high. While the beam is inside the visible window, a render strobe fires with the current coordinates. On the last dot of every line, a prefetch strobe names the line that comes next, so that a sprite fetch unit can prepare it. Pixel fetching, compositing and output belong to other blocks.

The block also keeps four status bits: vertical blank, the interrupt request, sprite-zero hit and sprite overflow. Vertical blank rises at the first dot below the visible window and falls at the first dot of a frame. The interrupt request rises together with vertical blank when the interrupt enable is set. A processor status read clears both vertical blank and the interrupt request. Other logic sets the two sprite bits, and this block clears them at the start of each visible line.

Top module: `raster_timing_gen`

## Requirements
- R1: `dot_x` counts 0 to LINE_DOTS-1 and then returns to 0. That wrap moves `dot_y` forward by one, and `dot_y` returns to 0 after line FRAME_LINES-1. Both counters are 0 after reset.
- R2: On an edge where `dot_en` is low, the counters and every timed event hold. `render_stb` and `prefetch_stb` stay low in such cycles.
- R3: `render_stb` is high in a cycle exactly when `dot_en` is high, `dot_x` < VIS_W and `dot_y` < VIS_H.
- R4: `prefetch_stb` is high when `dot_en` is high and `dot_x` = LINE_DOTS-1, on every line. In that cycle `prefetch_line` equals `dot_y`+1, or 0 on line FRAME_LINES-1.
- R5: `vblank` goes to 1 after an enabled edge at dot 0 of line VIS_H. It goes to 0 after an enabled edge at dot 0 of line 0.
- R6: A cycle with `status_rd` high makes `vblank` and `nmi` 0 after the edge. This wins over a set that falls in the same cycle.
- R7: `nmi` goes to 1 along with `vblank` when `nmi_enable` is high in the cycle where vertical blank starts. It stays 1 until a status read or until vertical blank ends at the top of the frame.
- R8: `hit_set` and `ovf_set` set `spr0_hit` and `spr_ovf`. An enabled edge at dot 0 of a line below VIS_H clears both, and the clear wins over a set in the same cycle. Dot 0 of a blanking line does not clear them.
- R9: Driving `rst_n` low clears the counters and all four status bits at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_en | input | 1 | Dot clock enable |
| nmi_enable | input | 1 | Interrupt enable bit from the control register |
| status_rd | input | 1 | Status register read pulse |
| hit_set | input | 1 | Sets the sprite-zero hit bit |
| ovf_set | input | 1 | Sets the sprite overflow bit |
| dot_x | output | XW | Current horizontal dot |
| dot_y | output | YW | Current line |
| render_stb | output | 1 | Visible dot strobe |
| prefetch_stb | output | 1 | Last-dot strobe asking for the next line's sprites |
| prefetch_line | output | YW | Line to prefetch |
| vblank | output | 1 | Vertical blank flag |
| nmi | output | 1 | Interrupt request |
| spr0_hit | output | 1 | Sprite-zero hit flag |
| spr_ovf | output | 1 | Sprite overflow flag |

## Verification
Two pairs of events can fall in the same cycle: a status read against the counter-driven start of vertical blank, and a sprite flag set against the line-start clear. The bench makes each pair collide by pulsing `status_rd` at dot 0 of line VIS_H, and `hit_set` at dot 0 of a visible line. After the edge it expects `vblank`, `nmi` and `spr0_hit` all at 0. It then repeats the sprite case on a blanking line, where the set must survive.

// File: rtl/raster_pkg.sv
package raster_pkg;

  typedef struct packed {
    logic vblank;
    logic nmi;
    logic hit;
    logic ovf;
  } stat_t;

  typedef struct packed {
    logic frame_top;
    logic vblank_start;
    logic line_top_vis;
  } tick_t;

endpackage

// File: rtl/raster_counter.sv
module raster_counter #(
  parameter int LINE_DOTS   = 341,
  parameter int FRAME_LINES = 262,
  parameter int XW          = $clog2(LINE_DOTS),
  parameter int YW          = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dot_en,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y,
  output logic          last_x,
  output logic          last_y
);

  localparam logic [XW-1:0] X_LAST = XW'(LINE_DOTS - 1);
  localparam logic [YW-1:0] Y_LAST = YW'(FRAME_LINES - 1);

  logic [XW-1:0] x_nxt;
  logic [YW-1:0] y_nxt;

  assign last_x = (x == X_LAST);
  assign last_y = (y == Y_LAST);

  always_comb begin
    x_nxt = x;
    y_nxt = y;
    if (dot_en) begin
      if (last_x) begin
        x_nxt = '0;
        y_nxt = last_y ? '0 : y + 1'b1;
      end else begin
        x_nxt = x + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x <= '0;
      y <= '0;
    end else begin
      x <= x_nxt;
      y <= y_nxt;
    end
  end

endmodule

// File: rtl/raster_decode.sv
module raster_decode
  import raster_pkg::*;
#(
  parameter int VIS_W = 256,
  parameter int VIS_H = 240,
  parameter int XW    = 9,
  parameter int YW    = 9
) (
  input  logic          dot_en,
  input  logic [XW-1:0] x,
  input  logic [YW-1:0] y,
  input  logic          last_x,
  input  logic          last_y,
  output logic          render_stb,
  output logic          prefetch_stb,
  output logic [YW-1:0] prefetch_line,
  output tick_t         tick
);

  localparam logic [XW-1:0] X_VIS = XW'(VIS_W);
  localparam logic [YW-1:0] Y_VIS = YW'(VIS_H);

  logic y_in_vis;
  logic line_top;

  assign y_in_vis = (y < Y_VIS);
  assign line_top = dot_en && (x == '0);

  always_comb begin
    render_stb        = dot_en && (x < X_VIS) && y_in_vis;
    prefetch_stb      = dot_en && last_x;
    prefetch_line     = last_y ? '0 : y + 1'b1;
    tick.frame_top    = line_top && (y == '0);
    tick.vblank_start = line_top && (y == Y_VIS);
    tick.line_top_vis = line_top && y_in_vis;
  end

endmodule

// File: rtl/raster_status.sv
module raster_status
  import raster_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  tick_t tick,
  input  logic  nmi_enable,
  input  logic  status_rd,
  input  logic  hit_set,
  input  logic  ovf_set,
  output stat_t stat
);

  stat_t stat_nxt;

  always_comb begin
    stat_nxt = stat;
    // vertical blank: read beats the counter-driven set
    if (status_rd)              stat_nxt.vblank = 1'b0;
    else if (tick.vblank_start) stat_nxt.vblank = 1'b1;
    else if (tick.frame_top)    stat_nxt.vblank = 1'b0;
    // interrupt request follows the same priority
    if (status_rd || tick.frame_top)           stat_nxt.nmi = 1'b0;
    else if (tick.vblank_start && nmi_enable)  stat_nxt.nmi = 1'b1;
    // sprite flags: line-start clear beats a set
    if (tick.line_top_vis) begin
      stat_nxt.hit = 1'b0;
      stat_nxt.ovf = 1'b0;
    end else begin
      if (hit_set) stat_nxt.hit = 1'b1;
      if (ovf_set) stat_nxt.ovf = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= stat_nxt;
  end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int LINE_DOTS   = 341,
  parameter int FRAME_LINES = 262,
  parameter int VIS_W       = 256,
  parameter int VIS_H       = 240,
  parameter int XW          = $clog2(LINE_DOTS),
  parameter int YW          = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dot_en,
  input  logic          nmi_enable,
  input  logic          status_rd,
  input  logic          hit_set,
  input  logic          ovf_set,
  output logic [XW-1:0] dot_x,
  output logic [YW-1:0] dot_y,
  output logic          render_stb,
  output logic          prefetch_stb,
  output logic [YW-1:0] prefetch_line,
  output logic          vblank,
  output logic          nmi,
  output logic          spr0_hit,
  output logic          spr_ovf
);

  logic [1:0] rst_sync;
  logic       rst_core_n;
  logic       last_x;
  logic       last_y;
  tick_t      tick;
  stat_t      stat;

  // assert asynchronously, release after two clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  raster_counter #(
    .LINE_DOTS(LINE_DOTS), .FRAME_LINES(FRAME_LINES), .XW(XW), .YW(YW)
  ) i_counter (
    .clk(clk), .rst_n(rst_core_n), .dot_en(dot_en),
    .x(dot_x), .y(dot_y), .last_x(last_x), .last_y(last_y)
  );

  raster_decode #(
    .VIS_W(VIS_W), .VIS_H(VIS_H), .XW(XW), .YW(YW)
  ) i_decode (
    .dot_en(dot_en), .x(dot_x), .y(dot_y), .last_x(last_x), .last_y(last_y),
    .render_stb(render_stb), .prefetch_stb(prefetch_stb),
    .prefetch_line(prefetch_line), .tick(tick)
  );

  raster_status i_status (
    .clk(clk), .rst_n(rst_core_n), .tick(tick), .nmi_enable(nmi_enable),
    .status_rd(status_rd), .hit_set(hit_set), .ovf_set(ovf_set), .stat(stat)
  );

  assign vblank   = stat.vblank;
  assign nmi      = stat.nmi;
  assign spr0_hit = stat.hit;
  assign spr_ovf  = stat.ovf;

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int LINE_DOTS   = 341,
  parameter int FRAME_LINES = 262,
  parameter int VIS_W       = 256,
  parameter int VIS_H       = 240,
  parameter int XW          = 9,
  parameter int YW          = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dot_en,
  input logic          status_rd,
  input logic [XW-1:0] dot_x,
  input logic [YW-1:0] dot_y,
  input logic          prefetch_stb,
  input logic [YW-1:0] prefetch_line,
  input logic          vblank,
  input logic          nmi,
  input logic          spr0_hit,
  input logic          spr_ovf
);

  localparam logic [XW-1:0] X_LAST = XW'(LINE_DOTS - 1);
  localparam logic [YW-1:0] Y_VIS  = YW'(VIS_H);

  AST_X_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    dot_en && dot_x == X_LAST |=> dot_x == '0);  // R1

  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dot_en && dot_x != X_LAST |=> dot_x == $past(dot_x) + 1'b1);  // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dot_en |=> $stable(dot_x) && $stable(dot_y));  // R2

  AST_PREFETCH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    prefetch_stb |=> dot_x == '0 && dot_y == $past(prefetch_line));  // R4

  AST_VBLANK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    dot_en && dot_x == '0 && dot_y == Y_VIS && !status_rd |=> vblank);  // R5

  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> !vblank && !nmi);  // R6

  AST_NMI_IN_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> vblank);  // R7

  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    dot_en && dot_x == '0 && dot_y < Y_VIS |=> !spr0_hit && !spr_ovf);  // R8

endmodule

bind raster_timing_gen raster_timing_chk #(
  .LINE_DOTS(LINE_DOTS), .FRAME_LINES(FRAME_LINES),
  .VIS_W(VIS_W), .VIS_H(VIS_H), .XW(XW), .YW(YW)
) i_chk (
  .clk(clk), .rst_n(rst_core_n), .dot_en(dot_en), .status_rd(status_rd),
  .dot_x(dot_x), .dot_y(dot_y), .prefetch_stb(prefetch_stb),
  .prefetch_line(prefetch_line), .vblank(vblank), .nmi(nmi),
  .spr0_hit(spr0_hit), .spr_ovf(spr_ovf)
);

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;

  localparam int L  = 20;
  localparam int F  = 12;
  localparam int W  = 16;
  localparam int H  = 8;
  localparam int XW = $clog2(L);
  localparam int YW = $clog2(F);

  typedef struct packed {
    int x; int y; bit nen; bit rd; bit ren; bit pf; int pfl; bit vb; bit nmi;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{5,  2,  1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0},
    '{16, 2,  1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0},
    '{19, 3,  1'b0, 1'b0, 1'b0, 1'b1, 4, 1'b0, 1'b0},
    '{0,  8,  1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b1, 1'b1},
    '{3,  8,  1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0},
    '{19, 11, 1'b0, 1'b0, 1'b0, 1'b1, 0, 1'b0, 1'b0},
    '{0,  0,  1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0},
    '{0,  8,  1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b1, 1'b0},
    '{0,  0,  1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0},
    '{0,  8,  1'b1, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0},
    '{0,  8,  1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b1, 1'b1},
    '{0,  0,  1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, dot_en, nmi_enable, status_rd, hit_set, ovf_set;
  logic [XW-1:0] dot_x;
  logic [YW-1:0] dot_y, prefetch_line;
  logic render_stb, prefetch_stb, vblank, nmi, spr0_hit, spr_ovf;

  raster_timing_gen #(.LINE_DOTS(L), .FRAME_LINES(F), .VIS_W(W), .VIS_H(H))
  i_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .nmi_enable(nmi_enable),
    .status_rd(status_rd), .hit_set(hit_set), .ovf_set(ovf_set),
    .dot_x(dot_x), .dot_y(dot_y), .render_stb(render_stb),
    .prefetch_stb(prefetch_stb), .prefetch_line(prefetch_line),
    .vblank(vblank), .nmi(nmi), .spr0_hit(spr0_hit), .spr_ovf(spr_ovf)
  );

  int checks = 0;
  int errors = 0;
  int bx = 0;
  int by = 0;
  int hx, hy;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (dot_en) begin
      if (bx == L - 1) begin
        bx = 0;
        by = (by == F - 1) ? 0 : by + 1;
      end else begin
        bx = bx + 1;
      end
    end
    @(negedge clk);
  endtask

  task automatic go_to(int x, int y);
    while (!(bx == x && by == y)) step();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; dot_en = 1'b0; nmi_enable = 1'b0;
    status_rd = 1'b0; hit_set = 1'b0; ovf_set = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "dot_x", int'(dot_x), 0);
    check("R9", "dot_y", int'(dot_y), 0);
    check("R9", "vblank", int'(vblank), 0);
    check("R9", "nmi", int'(nmi), 0);
    check("R9", "spr0_hit", int'(spr0_hit), 0);
    check("R9", "spr_ovf", int'(spr_ovf), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    dot_en = 1'b1;

    for (int i = 0; i < NV; i++) begin
      go_to(VEC[i].x, VEC[i].y);
      nmi_enable = VEC[i].nen;
      status_rd  = VEC[i].rd;
      #1;
      check("R1", "dot_x", int'(dot_x), bx);
      check("R1", "dot_y", int'(dot_y), by);
      check("R3", "render_stb", int'(render_stb), int'(VEC[i].ren));
      check("R4", "prefetch_stb", int'(prefetch_stb), int'(VEC[i].pf));
      if (VEC[i].pf) check("R4", "prefetch_line", int'(prefetch_line), VEC[i].pfl);
      step();
      check(VEC[i].rd ? "R6" : "R5", "vblank", int'(vblank), int'(VEC[i].vb));
      check(VEC[i].rd ? "R6" : "R7", "nmi", int'(nmi), int'(VEC[i].nmi));
      nmi_enable = 1'b0;
      status_rd  = 1'b0;
    end

    // R2: disabled edges freeze position and suppress strobes
    dot_en = 1'b0;
    hx = int'(dot_x); hy = int'(dot_y);
    repeat (5) step();
    check("R2", "dot_x held", int'(dot_x), hx);
    check("R2", "dot_y held", int'(dot_y), hy);
    check("R2", "render_stb idle", int'(render_stb), 0);
    dot_en = 1'b1;

    // R8: set, then line-start clear
    go_to(5, 3);
    hit_set = 1'b1; ovf_set = 1'b1;
    step();
    hit_set = 1'b0; ovf_set = 1'b0;
    check("R8", "hit set", int'(spr0_hit), 1);
    check("R8", "ovf set", int'(spr_ovf), 1);
    go_to(0, 4);
    check("R8", "hit before line start", int'(spr0_hit), 1);
    step();
    check("R8", "hit cleared", int'(spr0_hit), 0);
    check("R8", "ovf cleared", int'(spr_ovf), 0);
    // R8 collision: clear wins
    go_to(0, 5);
    hit_set = 1'b1;
    step();
    hit_set = 1'b0;
    check("R8", "hit vs clear", int'(spr0_hit), 0);
    // R8 blanking line keeps flag
    go_to(3, 8);
    hit_set = 1'b1;
    step();
    hit_set = 1'b0;
    go_to(0, 9);
    step();
    check("R8", "hit kept in blank", int'(spr0_hit), 1);
    check("R5", "vblank in blank", int'(vblank), 1);

    // R9: asynchronous reset mid-frame
    @(posedge clk); #1;
    rst_n = 1'b0;
    #0.5;
    check("R9", "async dot_x", int'(dot_x), 0);
    check("R9", "async dot_y", int'(dot_y), 0);
    check("R9", "async vblank", int'(vblank), 0);
    check("R9", "async spr0_hit", int'(spr0_hit), 0);
    finish_run();
  end

endmodule